// File: doc/BRIEF.md
# Scan Test Protocol Sequencer

This block is a finite-state controller that drives a scan chain through the basic scan test sequence for a run of one or more stimulus patterns. A single start pulse begins the run. The controller first shifts the first pattern into the chain with scan enable high, pulling one stimulus bit per cycle from a serial pattern source. It then drops scan enable and raises a one-cycle strobe that tells the surrounding fixture to apply the primary-input values. It waits a programmable number of settle cycles and raises a one-cycle primary-output sample strobe. After that it pulses the capture clock enable of each clock domain in turn, one domain per cycle, in ascending index order.

After one quiet cycle, scan enable rises again. The controller unloads the captured response through a serial response sink and, in the same shift, loads the next pattern if one remains. After the unload of the last pattern, a one-cycle done pulse is issued and the controller returns to idle. Issuing the domain captures in separate cycles keeps the result of any one domain independent of clock skew between domains.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is high and afterwards until a start is accepted, scan_en, pat_rd, scan_in, resp_vld, pi_apply, po_strobe, every cap_en bit, busy and done are all 0.
- R2: The first cycle after the clock edge that samples start high in idle begins a load of exactly CHAIN_LEN cycles. In each of these cycles scan_en=1 and pat_rd=1, scan_in equals pat_bit, and resp_vld=0.
- R3: Each shift phase that loads a pattern is followed by exactly one cycle with pi_apply=1 and scan_en=0.
- R4: After pi_apply, the block waits max(1, settle_cycles) cycles. In these cycles scan_en, po_strobe, pi_apply and all cap_en bits are 0, and a settle_cycles value of 0 is treated as 1.
- R5: po_strobe is 1 for exactly one cycle directly after the settle wait and before the first capture cycle of the same pattern.
- R6: Capture lasts NUM_DOM consecutive cycles with scan_en=0. In the cycle at offset d, cap_en has only bit d set (domain 0 first).
- R7: After the last capture cycle there is exactly one cycle with scan_en=0 and no other strobe, and then an unload shift begins.
- R8: An unload shift lasts CHAIN_LEN cycles with scan_en=1 and resp_vld=1, and resp_bit equals chain_so. In the same shift, pat_rd=1 and scan_in=pat_bit when another pattern remains; otherwise pat_rd=0 and scan_in=0.
- R9: A run handles num_patterns patterns, with 0 treated as 1. The pattern count is sampled together with start.
- R10: done is 1 for exactly one cycle, directly after the last unload shift. In the next cycle busy=0 and the block is idle. busy is 1 from the first load cycle through the done cycle.
- R11: A start pulse that arrives while a run is in progress is ignored, and the run's timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled in idle only) |
| num_patterns | input | PAT_W | Pattern count for the run, 0 means 1 |
| settle_cycles | input | SETTLE_W | Propagate wait in cycles, 0 means 1 |
| pat_bit | input | 1 | Next stimulus bit from the pattern source |
| pat_rd | output | 1 | Stimulus bit consumed this cycle |
| chain_so | input | 1 | Serial output of the chain under test |
| scan_en | output | 1 | Scan mode select for the chain |
| scan_in | output | 1 | Serial input to the chain |
| pi_apply | output | 1 | Apply primary-input values |
| po_strobe | output | 1 | Sample primary outputs |
| cap_en | output | NUM_DOM | Per-domain capture clock enables |
| resp_bit | output | 1 | Response bit to the sink |
| resp_vld | output | 1 | resp_bit is valid this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench runs the sequence against a behavioural chain model. In that model, each domain capture inverts the cells whose index modulo NUM_DOM equals that domain. Every unloaded bit must therefore be the inverse of the stimulus bit that went in at the same shift position. A skipped or repeated domain pulse, a shift one cycle too long or too short, or a bit that is captured twice all show up as data errors. Runs with one, two and three patterns tell the overlapping load/unload apart from the bare final unload. Settle values of 0, 1, 2 and 5 separate the clamp from the plain wait. A start pulse in the middle of a run checks that the cycle-exact phase trace is unchanged.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_APPLY,
        ST_SETTLE,
        ST_MEASURE,
        ST_CAPTURE,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic shift;
        logic pat_rd;
        logic resp_vld;
        logic pi_apply;
        logic po_strobe;
        logic cap_active;
        logic done;
        logic busy;
    } seq_ctl_t;

    function automatic int clamp_min1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/scan_phase_cnt.sv
module scan_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/scan_dom_dec.sv
module scan_dom_dec #(
    parameter int NUM_DOM = 3,
    parameter int DOM_W   = 2
) (
    input  logic               en,
    input  logic [DOM_W-1:0]   idx,
    output logic [NUM_DOM-1:0] cap_en
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign cap_en[d] = en && (idx == DOM_W'(d));
    end
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int NUM_DOM   = 3,
    parameter int PAT_W     = 4,
    parameter int SETTLE_W  = 4,
    parameter int CNT_W     = 5,
    parameter int DOM_W     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [PAT_W-1:0]    num_patterns,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                cnt_zero,
    output logic                cnt_load,
    output logic [CNT_W-1:0]    cnt_val,
    output logic [DOM_W-1:0]    dom_idx,
    output seq_ctl_t            ctl
);
    seq_state_e       state, state_nx;
    logic [PAT_W-1:0] pats_left;
    logic             first;
    logic             loading;

    assign loading = (pats_left != '0);

    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_IDLE: if (start) begin
                state_nx = ST_SHIFT;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(CHAIN_LEN - 1);
            end
            ST_SHIFT: if (cnt_zero) begin
                state_nx = loading ? ST_APPLY : ST_DONE;
            end
            ST_APPLY: begin
                state_nx = ST_SETTLE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(clamp_min1(int'(settle_cycles)) - 1);
            end
            ST_SETTLE: if (cnt_zero) state_nx = ST_MEASURE;
            ST_MEASURE: begin
                state_nx = ST_CAPTURE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(NUM_DOM - 1);
            end
            ST_CAPTURE: if (cnt_zero) state_nx = ST_GAP;
            ST_GAP: begin
                state_nx = ST_SHIFT;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(CHAIN_LEN - 1);
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pats_left <= '0;
            first     <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                pats_left <= (num_patterns == '0) ? PAT_W'(1) : num_patterns;
                first     <= 1'b1;
            end else if (state == ST_SHIFT && cnt_zero) begin
                first <= 1'b0;
                if (loading) pats_left <= pats_left - 1'b1;
            end
        end
    end

    // Capture walks the counter down, so the domain index counts up.
    assign dom_idx = DOM_W'((NUM_DOM - 1) - int'(cnt));

    always_comb begin
        ctl            = '0;
        ctl.shift      = (state == ST_SHIFT);
        ctl.pat_rd     = (state == ST_SHIFT) && loading;
        ctl.resp_vld   = (state == ST_SHIFT) && !first;
        ctl.pi_apply   = (state == ST_APPLY);
        ctl.po_strobe  = (state == ST_MEASURE);
        ctl.cap_active = (state == ST_CAPTURE);
        ctl.done       = (state == ST_DONE);
        ctl.busy       = (state != ST_IDLE);
    end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int NUM_DOM   = 3,
    parameter int PAT_W     = 4,
    parameter int SETTLE_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [PAT_W-1:0]    num_patterns,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                pat_bit,
    output logic                pat_rd,
    input  logic                chain_so,
    output logic                scan_en,
    output logic                scan_in,
    output logic                pi_apply,
    output logic                po_strobe,
    output logic [NUM_DOM-1:0]  cap_en,
    output logic                resp_bit,
    output logic                resp_vld,
    output logic                busy,
    output logic                done
);
    localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
    localparam int CNT_W = max3($clog2(CHAIN_LEN + 1), SETTLE_W + 1, DOM_W + 1);

    seq_ctl_t         ctl;
    logic             cnt_load, cnt_zero;
    logic [CNT_W-1:0] cnt_val, cnt;
    logic [DOM_W-1:0] dom_idx;

    scan_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
        .cnt(cnt), .zero(cnt_zero)
    );

    scan_seq_fsm #(
        .CHAIN_LEN(CHAIN_LEN), .NUM_DOM(NUM_DOM), .PAT_W(PAT_W),
        .SETTLE_W(SETTLE_W), .CNT_W(CNT_W), .DOM_W(DOM_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .num_patterns(num_patterns),
        .settle_cycles(settle_cycles), .cnt(cnt), .cnt_zero(cnt_zero),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .dom_idx(dom_idx), .ctl(ctl)
    );

    scan_dom_dec #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_dec (
        .en(ctl.cap_active), .idx(dom_idx), .cap_en(cap_en)
    );

    assign scan_en   = ctl.shift;
    assign pat_rd    = ctl.pat_rd;
    assign scan_in   = ctl.pat_rd & pat_bit;
    assign resp_vld  = ctl.resp_vld;
    assign resp_bit  = ctl.resp_vld & chain_so;
    assign pi_apply  = ctl.pi_apply;
    assign po_strobe = ctl.po_strobe;
    assign busy      = ctl.busy;
    assign done      = ctl.done;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int NUM_DOM = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               scan_en,
    input logic               pat_rd,
    input logic               pi_apply,
    input logic               po_strobe,
    input logic [NUM_DOM-1:0] cap_en,
    input logic               resp_vld,
    input logic               busy,
    input logic               done
);
    // R6
    cap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cap_en));

    // R6
    cap_no_scan_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_en != '0) |-> !scan_en);

    // R5
    po_then_dom0_chk: assert property (@(posedge clk) disable iff (rst)
        po_strobe |=> (cap_en == NUM_DOM'(1)));

    // R7
    gap_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en[NUM_DOM-1] |=> (!scan_en && cap_en == '0 && !po_strobe));

    // R3
    apply_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pi_apply |-> (!scan_en && $past(scan_en)));

    // R8
    resp_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_vld || pat_rd) |-> scan_en);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);
endmodule

bind scan_seq_top scan_seq_chk #(.NUM_DOM(NUM_DOM)) u_chk (
    .clk(clk), .rst(rst), .start(start), .scan_en(scan_en), .pat_rd(pat_rd),
    .pi_apply(pi_apply), .po_strobe(po_strobe), .cap_en(cap_en),
    .resp_vld(resp_vld), .busy(busy), .done(done)
);

// File: tb/tb_scan_seq_top.sv
module tb_scan_seq_top;
    localparam int L  = 8;
    localparam int D  = 3;
    localparam int PW = 4;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [PW-1:0] num_patterns = '0;
    logic [SW-1:0] settle_cycles = '0;
    logic          pat_bit, pat_rd, chain_so, scan_en, scan_in;
    logic          pi_apply, po_strobe, resp_bit, resp_vld, busy, done;
    logic [D-1:0]  cap_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    scan_seq_top #(.CHAIN_LEN(L), .NUM_DOM(D), .PAT_W(PW), .SETTLE_W(SW)) dut (
        .clk(clk), .rst(rst), .start(start), .num_patterns(num_patterns),
        .settle_cycles(settle_cycles), .pat_bit(pat_bit), .pat_rd(pat_rd),
        .chain_so(chain_so), .scan_en(scan_en), .scan_in(scan_in),
        .pi_apply(pi_apply), .po_strobe(po_strobe), .cap_en(cap_en),
        .resp_bit(resp_bit), .resp_vld(resp_vld), .busy(busy), .done(done)
    );

    function automatic logic patf(input int k, input int t);
        logic [31:0] seed;
        seed = 32'hA5C3_96E1;
        return seed[(k * 5 + t * 3) % 32];
    endfunction

    // Pattern source and chain model: capture on domain d inverts cells j%D==d.
    int       pk = 0, pidx = 0;
    logic [L-1:0] chain = '0;
    assign pat_bit  = patf(pk, pidx);
    assign chain_so = chain[L-1];

    always @(posedge clk) begin
        if (pat_rd) begin
            if (pidx == L - 1) begin
                pidx <= 0;
                pk   <= pk + 1;
            end else begin
                pidx <= pidx + 1;
            end
        end
        if (scan_en) begin
            chain <= {chain[L-2:0], scan_in};
        end else begin
            for (int j = 0; j < L; j++)
                if (cap_en[j % D]) chain[j] <= ~chain[j];
        end
    end

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog expired: run did not end");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pack_out();
        return {scan_en, pat_rd, resp_vld, pi_apply, po_strobe, done, busy, cap_en};
    endfunction

    function automatic int pack_exp(input logic se, input logic prd, input logic rv,
                                    input logic pia, input logic pos, input logic dn,
                                    input logic bsy, input logic [D-1:0] cap);
        return {se, prd, rv, pia, pos, dn, bsy, cap};
    endfunction

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {pack_out(), scan_in}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", {pack_out(), scan_in}, 0);
    endtask

    // One run of n patterns; every cycle is compared against the phase plan.
    task automatic run_protocol(input int n, input int s, input bit extra_start);
        int neff, seff, per, total, rk, ridx, base, c;
        neff = (n == 0) ? 1 : n;
        seff = (s == 0) ? 1 : s;
        per  = L + 3 + seff + D;
        total = L + 1 + neff * per;
        base = pk;
        rk = base;
        ridx = 0;
        num_patterns  = PW'(n);
        settle_cycles = SW'(s);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (c = 1; c <= total + 1; c++) begin
            int e, o, k, cp;
            string req;
            if (extra_start && c == 5) start = 1'b1;
            if (extra_start && c == 6) start = 1'b0;
            if (c <= L) begin
                e = pack_exp(1, 1, 0, 0, 0, 0, 1, '0);
                req = "R2 load phase";
            end else if (c == total) begin
                e = pack_exp(0, 0, 0, 0, 0, 1, 1, '0);
                req = "R10 done pulse";
            end else if (c == total + 1) begin
                e = 0;
                req = "R10 back to idle";
            end else begin
                cp = c - L - 1;
                k = cp / per;
                o = cp % per;
                if (o == 0) begin
                    e = pack_exp(0, 0, 0, 1, 0, 0, 1, '0);
                    req = "R3 apply";
                end else if (o <= seff) begin
                    e = pack_exp(0, 0, 0, 0, 0, 0, 1, '0);
                    req = "R4 settle";
                end else if (o == seff + 1) begin
                    e = pack_exp(0, 0, 0, 0, 1, 0, 1, '0);
                    req = "R5 po strobe";
                end else if (o <= seff + 1 + D) begin
                    e = pack_exp(0, 0, 0, 0, 0, 0, 1, D'(1 << (o - seff - 2)));
                    req = "R6 capture";
                end else if (o == seff + 2 + D) begin
                    e = pack_exp(0, 0, 0, 0, 0, 0, 1, '0);
                    req = "R7 gap";
                end else begin
                    e = pack_exp(1, (k < neff - 1), 1, 0, 0, 0, 1, '0);
                    req = "R8 unload shift";
                end
            end
            if (extra_start) req = {req, " R11"};
            if (n == 0) req = {req, " R9"};
            check(req, pack_out(), e);
            if (resp_vld) begin
                check("R8 response bit", resp_bit, !patf(rk, ridx));
                if (ridx == L - 1) begin
                    ridx = 0;
                    rk++;
                end else begin
                    ridx++;
                end
            end
            if (pat_rd) check("R2 scan_in follows pat_bit", scan_in, pat_bit);
            else check("R8 scan_in quiet", scan_in, 0);
            @(negedge clk);
        end
        check("R9 patterns loaded", pk - base, neff);
        check("R9 responses unloaded", rk - base, neff);
    endtask

    initial begin
        test_reset();
        run_protocol(1, 2, 1'b0);
        run_protocol(3, 1, 1'b0);
        run_protocol(2, 0, 1'b0);
        run_protocol(0, 5, 1'b0);
        run_protocol(2, 3, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule